// File: doc/BRIEF.md
# Floppy Controller Mode and Lock Registers

This block keeps the command-programmed operating state of a floppy disk controller. Three state groups are held. The first is a global two-bit perpendicular recording mode. The second is a per-drive perpendicular select mask. The third is a set of configuration values: a FIFO-off flag, a FIFO threshold and a precompensation start track, with a lock flag that guards them. A command decoder elsewhere delivers the decoded fields of the mode, configure and lock commands as one-cycle strobes.

For the drive and data rate selected on its query inputs, the block reports four things. These are whether perpendicular recording is in force, the GAP2 field length in bytes, how many GAP2 bytes a write-data operation rewrites, and the write precompensation to apply.

The two kinds of reset act differently:
- A hardware reset (`rst_n` low) returns everything to its default.
- A software reset (`sw_reset`) always clears the global mode and keeps the per-drive mask.
- A software reset restores the configuration values only when the lock flag is clear.

A lock command returns a one-byte status reply on the next cycle. A small reply state machine has two states. `ST_IDLE` moves to `ST_REPLY` on an accepted lock command. `ST_REPLY` goes back to `ST_IDLE` after one cycle, or stays in `ST_REPLY` if another lock command is accepted. A software reset forces `ST_IDLE`.

Top module: `fdc_mode_lock`

## Requirements
- R1: After a hardware reset the outputs and state are as follows. The global mode is conventional and the per-drive mask is 0000. The lock flag is 0. `fifo_off`=1, `fifo_thresh`=0, `precomp_trk`=0 and `status_valid`=0. Every drive reports conventional with GAP2 length 22 and rewrite 0.
- R2: A mode command (`mode_cmd`=1) loads `mode_mask` into the per-drive mask only when `mode_wr_en`=1. With `mode_wr_en`=0 the mask keeps its old value. In both cases the global mode bits are loaded from the command.
- R3: The global mode code is {`mode_m1`,`mode_m0`}. When it is 00, the selected drive is perpendicular if its mask bit is 1 (bit i belongs to drive i) and conventional if it is 0. For any other code the mask is ignored.
- R4: The global codes give these outputs. Code 10 makes every drive perpendicular with length 22 and rewrite 19. Code 11 makes every drive perpendicular with length 41 and rewrite 38. Code 01 is reserved and behaves as conventional for every drive, with length 22 and rewrite 0.
- R5: A drive that is perpendicular through its mask bit takes its sizing from `rate_sel`. Code 11 (1 Mbps) gives length 41 and rewrite 38. Codes 00, 01 and 10 give length 22 and rewrite 19.
- R6: `precomp_eff` is 0 when the selected drive is perpendicular. Otherwise it equals `precomp_prog`.
- R7: A software reset sets the global mode to 00 on the next edge and leaves the per-drive mask unchanged.
- R8: On a software reset, the configuration values return to their defaults (1, 0, 0) if the lock flag is 0. If the lock flag is 1 they keep their values.
- R9: A lock command accepted in one cycle sets the lock flag to `lock_val`. In the following cycle only, `status_valid` is 1 and `status_byte` carries the new lock flag in bit 4, with every other bit 0.
- R10: When a software reset and a command strobe arrive in the same cycle, the command is dropped. A software reset never changes the lock flag and ends any pending reply.
- R11: A configure command loads `cfg_fifo_off`, `cfg_thresh` and `cfg_pretrk` into the configuration outputs on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| sw_reset | input | 1 | Software reset pulse |
| mode_cmd | input | 1 | Mode command strobe |
| mode_m1 | input | 1 | Global mode code, upper bit |
| mode_m0 | input | 1 | Global mode code, lower bit |
| mode_wr_en | input | 1 | Allows the per-drive mask to be overwritten |
| mode_mask | input | 4 | Per-drive perpendicular select, bit i for drive i |
| cfg_cmd | input | 1 | Configure command strobe |
| cfg_fifo_off | input | 1 | FIFO-off value to load |
| cfg_thresh | input | 4 | FIFO threshold to load |
| cfg_pretrk | input | 8 | Precompensation start track to load |
| lock_cmd | input | 1 | Lock command strobe |
| lock_val | input | 1 | Lock flag value to load |
| drive_sel | input | 2 | Drive being queried |
| rate_sel | input | 2 | Data rate code, 11 = 1 Mbps |
| precomp_prog | input | 3 | Programmed write precompensation |
| perp_active | output | 1 | Selected drive is in perpendicular mode |
| gap2_len | output | 6 | GAP2 field length in bytes |
| gap2_rewrite | output | 6 | GAP2 bytes rewritten by a write |
| precomp_eff | output | 3 | Precompensation to apply |
| fifo_off | output | 1 | FIFO-off configuration value |
| fifo_thresh | output | 4 | FIFO threshold configuration value |
| precomp_trk | output | 8 | Precompensation start track |
| lock_state | output | 1 | Current lock flag |
| status_valid | output | 1 | Lock reply byte present |
| status_byte | output | 8 | Lock reply byte |

## Verification
The hardest situation to reach from the ports is a per-drive mask that was written earlier and has since been hidden by a global mode. It only shows again once a software reset clears the global mode. The stimulus sets a mask bit and then sets global code 11 over it. It then pulses `sw_reset` and queries that drive at a rate other than 1 Mbps, so that 22/19 sizing can only come from the kept mask bit. Same-cycle collisions of `sw_reset` with mode and lock commands are also driven directly. The bench then reads the lock flag and the mask-driven outputs to show that the dropped commands left no trace.

// File: rtl/fdc_mode_pkg.sv
package fdc_mode_pkg;

    localparam int NUM_DRV   = 4;
    localparam int DRV_W     = $clog2(NUM_DRV);
    localparam int RATE_W    = 2;
    localparam int LEN_W     = 6;
    localparam int THR_W     = 4;
    localparam int TRK_W     = 8;
    localparam int PCMP_W    = 3;
    localparam int STAT_W    = 8;
    localparam int LOCK_BIT  = 4;

    localparam logic [RATE_W-1:0] RATE_1M = 2'b11;

    localparam logic [LEN_W-1:0] LEN_SHORT = 6'd22;
    localparam logic [LEN_W-1:0] LEN_LONG  = 6'd41;
    localparam logic [LEN_W-1:0] REW_NONE  = 6'd0;
    localparam logic [LEN_W-1:0] REW_SHORT = 6'd19;
    localparam logic [LEN_W-1:0] REW_LONG  = 6'd38;

    localparam logic             DEF_FIFO_OFF = 1'b1;
    localparam logic [THR_W-1:0] DEF_THRESH   = '0;
    localparam logic [TRK_W-1:0] DEF_PRETRK   = '0;

    typedef enum logic [1:0] {
        MODE_CONV = 2'b00,
        MODE_RSVD = 2'b01,
        MODE_P500 = 2'b10,
        MODE_P1M  = 2'b11
    } glob_mode_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_REPLY = 1'b1
    } reply_st_e;

    typedef struct packed {
        logic             perp;
        logic [LEN_W-1:0] len;
        logic [LEN_W-1:0] rew;
    } gap_info_t;

endpackage

// File: rtl/fdc_perp_regs.sv
module fdc_perp_regs
    import fdc_mode_pkg::*;
#(
    parameter int N_DRV = NUM_DRV
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_reset,
    input  logic             mode_cmd,
    input  logic             mode_m1,
    input  logic             mode_m0,
    input  logic             mode_wr_en,
    input  logic [N_DRV-1:0] mode_mask,
    output glob_mode_e       glob_mode,
    output logic [N_DRV-1:0] drv_mask
);

    glob_mode_e       mode_q;
    logic [N_DRV-1:0] mask_q;

    logic cmd_take;
    assign cmd_take = mode_cmd && !sw_reset;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_CONV;
        end else if (sw_reset) begin
            mode_q <= MODE_CONV;
        end else if (cmd_take) begin
            mode_q <= glob_mode_e'({mode_m1, mode_m0});
        end
    end

    generate
        for (genvar i = 0; i < N_DRV; i++) begin : g_mask
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    mask_q[i] <= 1'b0;
                end else if (cmd_take && mode_wr_en) begin
                    mask_q[i] <= mode_mask[i];
                end
            end
        end
    endgenerate

    assign glob_mode = mode_q;
    assign drv_mask  = mask_q;

    // R2
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_cmd && !mode_wr_en) |=> $stable(mask_q));

    // R7
    swrst_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_reset |=> (mode_q == MODE_CONV) && $stable(mask_q));

    // R10
    swrst_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_reset && mode_cmd) |=> $stable(mask_q));

endmodule

// File: rtl/fdc_gap_decode.sv
module fdc_gap_decode
    import fdc_mode_pkg::*;
#(
    parameter int N_DRV = NUM_DRV,
    parameter int SEL_W = $clog2(N_DRV)
) (
    input  glob_mode_e        glob_mode,
    input  logic [N_DRV-1:0]  drv_mask,
    input  logic [SEL_W-1:0]  drive_sel,
    input  logic [RATE_W-1:0] rate_sel,
    output gap_info_t         info
);

    logic [N_DRV-1:0] drv_perp;
    logic             sel_perp;
    logic             fast;

    generate
        for (genvar i = 0; i < N_DRV; i++) begin : g_drv
            assign drv_perp[i] = (glob_mode == MODE_CONV) && drv_mask[i];
        end
    endgenerate

    assign sel_perp = drv_perp[drive_sel];
    assign fast     = (rate_sel == RATE_1M);

    always_comb begin
        info = '{perp: 1'b0, len: LEN_SHORT, rew: REW_NONE};
        unique case (glob_mode)
            MODE_P500: info = '{perp: 1'b1, len: LEN_SHORT, rew: REW_SHORT};
            MODE_P1M:  info = '{perp: 1'b1, len: LEN_LONG,  rew: REW_LONG};
            MODE_RSVD: info = '{perp: 1'b0, len: LEN_SHORT, rew: REW_NONE};
            MODE_CONV: begin
                if (sel_perp && fast) begin
                    info = '{perp: 1'b1, len: LEN_LONG, rew: REW_LONG};
                end else if (sel_perp) begin
                    info = '{perp: 1'b1, len: LEN_SHORT, rew: REW_SHORT};
                end else begin
                    info = '{perp: 1'b0, len: LEN_SHORT, rew: REW_NONE};
                end
            end
            default: info = '{perp: 1'b0, len: LEN_SHORT, rew: REW_NONE};
        endcase
    end

endmodule

// File: rtl/fdc_cfg_lock.sv
module fdc_cfg_lock
    import fdc_mode_pkg::*;
#(
    parameter int TW = THR_W,
    parameter int KW = TRK_W,
    parameter int SW = STAT_W,
    parameter int LB = LOCK_BIT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sw_reset,
    input  logic          cfg_cmd,
    input  logic          cfg_fifo_off,
    input  logic [TW-1:0] cfg_thresh,
    input  logic [KW-1:0] cfg_pretrk,
    input  logic          lock_cmd,
    input  logic          lock_val,
    output logic          fifo_off,
    output logic [TW-1:0] fifo_thresh,
    output logic [KW-1:0] precomp_trk,
    output logic          lock_state,
    output logic          status_valid,
    output logic [SW-1:0] status_byte
);

    logic          off_q;
    logic [TW-1:0] thr_q;
    logic [KW-1:0] trk_q;
    logic          lock_q;
    reply_st_e     st_q, st_d;

    logic lock_take;
    assign lock_take = lock_cmd && !sw_reset;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_q <= DEF_FIFO_OFF;
            thr_q <= TW'(DEF_THRESH);
            trk_q <= KW'(DEF_PRETRK);
        end else if (sw_reset) begin
            if (!lock_q) begin
                off_q <= DEF_FIFO_OFF;
                thr_q <= TW'(DEF_THRESH);
                trk_q <= KW'(DEF_PRETRK);
            end
        end else if (cfg_cmd) begin
            off_q <= cfg_fifo_off;
            thr_q <= cfg_thresh;
            trk_q <= cfg_pretrk;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_q <= 1'b0;
        end else if (lock_take) begin
            lock_q <= lock_val;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  st_d = lock_take ? ST_REPLY : ST_IDLE;
            ST_REPLY: st_d = lock_take ? ST_REPLY : ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
        if (sw_reset) st_d = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        status_valid    = 1'b0;
        status_byte     = '0;
        unique case (st_q)
            ST_IDLE:  status_valid = 1'b0;
            ST_REPLY: begin
                status_valid    = 1'b1;
                status_byte[LB] = lock_q;
            end
            default:  status_valid = 1'b0;
        endcase
    end

    assign fifo_off    = off_q;
    assign fifo_thresh = thr_q;
    assign precomp_trk = trk_q;
    assign lock_state  = lock_q;

    // R8
    locked_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_reset && lock_q) |=> $stable(off_q) && $stable(thr_q) && $stable(trk_q));

    // R8
    unlocked_dflt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_reset && !lock_q) |=> off_q && (thr_q == '0) && (trk_q == '0));

    // R9
    reply_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_cmd && !sw_reset) |=> status_valid &&
            (status_byte == (SW'(1) << LB) * SW'($past(lock_val))));

    // R10
    swrst_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_reset |=> $stable(lock_q) && !status_valid);

endmodule

// File: rtl/fdc_mode_lock.sv
module fdc_mode_lock
    import fdc_mode_pkg::*;
#(
    parameter int N_DRV = NUM_DRV,
    parameter int SEL_W = $clog2(N_DRV),
    parameter int PW    = PCMP_W,
    parameter int TW    = THR_W,
    parameter int KW    = TRK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_reset,
    input  logic              mode_cmd,
    input  logic              mode_m1,
    input  logic              mode_m0,
    input  logic              mode_wr_en,
    input  logic [N_DRV-1:0]  mode_mask,
    input  logic              cfg_cmd,
    input  logic              cfg_fifo_off,
    input  logic [TW-1:0]     cfg_thresh,
    input  logic [KW-1:0]     cfg_pretrk,
    input  logic              lock_cmd,
    input  logic              lock_val,
    input  logic [SEL_W-1:0]  drive_sel,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic [PW-1:0]     precomp_prog,
    output logic              perp_active,
    output logic [LEN_W-1:0]  gap2_len,
    output logic [LEN_W-1:0]  gap2_rewrite,
    output logic [PW-1:0]     precomp_eff,
    output logic              fifo_off,
    output logic [TW-1:0]     fifo_thresh,
    output logic [KW-1:0]     precomp_trk,
    output logic              lock_state,
    output logic              status_valid,
    output logic [STAT_W-1:0] status_byte
);

    glob_mode_e       glob_mode;
    logic [N_DRV-1:0] drv_mask;
    gap_info_t        info;

    fdc_perp_regs #(.N_DRV(N_DRV)) u_perp (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_reset   (sw_reset),
        .mode_cmd   (mode_cmd),
        .mode_m1    (mode_m1),
        .mode_m0    (mode_m0),
        .mode_wr_en (mode_wr_en),
        .mode_mask  (mode_mask),
        .glob_mode  (glob_mode),
        .drv_mask   (drv_mask)
    );

    fdc_gap_decode #(.N_DRV(N_DRV), .SEL_W(SEL_W)) u_dec (
        .glob_mode (glob_mode),
        .drv_mask  (drv_mask),
        .drive_sel (drive_sel),
        .rate_sel  (rate_sel),
        .info      (info)
    );

    fdc_cfg_lock #(.TW(TW), .KW(KW), .SW(STAT_W), .LB(LOCK_BIT)) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .sw_reset     (sw_reset),
        .cfg_cmd      (cfg_cmd),
        .cfg_fifo_off (cfg_fifo_off),
        .cfg_thresh   (cfg_thresh),
        .cfg_pretrk   (cfg_pretrk),
        .lock_cmd     (lock_cmd),
        .lock_val     (lock_val),
        .fifo_off     (fifo_off),
        .fifo_thresh  (fifo_thresh),
        .precomp_trk  (precomp_trk),
        .lock_state   (lock_state),
        .status_valid (status_valid),
        .status_byte  (status_byte)
    );

    assign perp_active  = info.perp;
    assign gap2_len     = info.len;
    assign gap2_rewrite = info.rew;
    assign precomp_eff  = info.perp ? '0 : precomp_prog;

    // R6
    perp_precomp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        perp_active |-> (precomp_eff == '0));

    // R4
    rewrite_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gap2_rewrite < gap2_len) && (perp_active == (gap2_rewrite != '0)));

    // R3
    rsvd_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (u_perp.glob_mode == MODE_RSVD) |-> !perp_active);

endmodule

// File: tb/fdc_mode_lock_test.sv
module fdc_mode_lock_test;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 10;
    localparam logic [2:0] PCMP = 3'd5;

    // {m1,m0,wr_en,mask[3:0],drive[1:0],rate[1:0],perp,len[5:0],rew[5:0]}
    localparam logic [23:0] VEC [NV] = '{
        {1'b0,1'b0,1'b1,4'b0101,2'd0,2'b00,1'b1,6'd22,6'd19}, // R3 R5
        {1'b0,1'b0,1'b1,4'b0101,2'd1,2'b00,1'b0,6'd22,6'd0},  // R3
        {1'b0,1'b0,1'b1,4'b0101,2'd2,2'b11,1'b1,6'd41,6'd38}, // R5
        {1'b0,1'b0,1'b1,4'b0101,2'd0,2'b10,1'b1,6'd22,6'd19}, // R5
        {1'b1,1'b0,1'b1,4'b0000,2'd3,2'b11,1'b1,6'd22,6'd19}, // R4
        {1'b1,1'b1,1'b1,4'b0000,2'd1,2'b00,1'b1,6'd41,6'd38}, // R4
        {1'b0,1'b1,1'b1,4'b1111,2'd0,2'b11,1'b0,6'd22,6'd0},  // R4 R3
        {1'b0,1'b0,1'b0,4'b0000,2'd0,2'b11,1'b1,6'd41,6'd38}, // R2
        {1'b0,1'b0,1'b1,4'b1000,2'd3,2'b01,1'b1,6'd22,6'd19}, // R2 R5
        {1'b0,1'b0,1'b1,4'b1000,2'd0,2'b01,1'b0,6'd22,6'd0}   // R2 R6
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sw_reset = 1'b0;
    logic mode_cmd = 1'b0, mode_m1 = 1'b0, mode_m0 = 1'b0, mode_wr_en = 1'b0;
    logic [3:0] mode_mask = '0;
    logic cfg_cmd = 1'b0, cfg_fifo_off = 1'b0;
    logic [3:0] cfg_thresh = '0;
    logic [7:0] cfg_pretrk = '0;
    logic lock_cmd = 1'b0, lock_val = 1'b0;
    logic [1:0] drive_sel = '0, rate_sel = '0;
    logic [2:0] precomp_prog = PCMP;
    logic perp_active, fifo_off, lock_state, status_valid;
    logic [5:0] gap2_len, gap2_rewrite;
    logic [2:0] precomp_eff;
    logic [3:0] fifo_thresh;
    logic [7:0] precomp_trk, status_byte;

    int n_run = 0;
    int n_fail = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fdc_mode_lock uut (
        .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset),
        .mode_cmd(mode_cmd), .mode_m1(mode_m1), .mode_m0(mode_m0),
        .mode_wr_en(mode_wr_en), .mode_mask(mode_mask),
        .cfg_cmd(cfg_cmd), .cfg_fifo_off(cfg_fifo_off),
        .cfg_thresh(cfg_thresh), .cfg_pretrk(cfg_pretrk),
        .lock_cmd(lock_cmd), .lock_val(lock_val),
        .drive_sel(drive_sel), .rate_sel(rate_sel), .precomp_prog(precomp_prog),
        .perp_active(perp_active), .gap2_len(gap2_len),
        .gap2_rewrite(gap2_rewrite), .precomp_eff(precomp_eff),
        .fifo_off(fifo_off), .fifo_thresh(fifo_thresh),
        .precomp_trk(precomp_trk), .lock_state(lock_state),
        .status_valid(status_valid), .status_byte(status_byte)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic check_query(input string tag, input logic [1:0] drv, input logic [1:0] rt,
                               input logic ep, input logic [5:0] el, input logic [5:0] er);
        drive_sel = drv;
        rate_sel  = rt;
        #1;
        check(tag, {perp_active, gap2_len, gap2_rewrite, precomp_eff},
                   {ep, el, er, (ep ? 3'd0 : PCMP)});
    endtask

    task automatic check_cfg(input string tag, input logic eo, input logic [3:0] et,
                             input logic [7:0] ek);
        check(tag, {fifo_off, fifo_thresh, precomp_trk}, {eo, et, ek});
    endtask

    task automatic mode_write(input logic m1, input logic m0, input logic we,
                              input logic [3:0] mk, input logic srst);
        mode_cmd = 1'b1; mode_m1 = m1; mode_m0 = m0; mode_wr_en = we; mode_mask = mk;
        sw_reset = srst;
        @(negedge clk);
        mode_cmd = 1'b0; sw_reset = 1'b0;
    endtask

    task automatic cfg_write(input logic o, input logic [3:0] t, input logic [7:0] k);
        cfg_cmd = 1'b1; cfg_fifo_off = o; cfg_thresh = t; cfg_pretrk = k;
        @(negedge clk);
        cfg_cmd = 1'b0;
    endtask

    task automatic lock_write(input logic v, input logic srst);
        lock_cmd = 1'b1; lock_val = v; sw_reset = srst;
        @(negedge clk);
        lock_cmd = 1'b0; sw_reset = 1'b0;
    endtask

    task automatic soft_reset();
        sw_reset = 1'b1;
        @(negedge clk);
        sw_reset = 1'b0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check_query("R1 query after reset", 2'd0, 2'b11, 1'b0, 6'd22, 6'd0);
        check_cfg("R1 cfg after reset", 1'b1, 4'd0, 8'd0);
        check("R1 lock/status after reset", {lock_state, status_valid}, 2'b00);

        // table of mode writes and queries
        for (int i = 0; i < NV; i++) begin
            logic [23:0] v;
            v = VEC[i];
            mode_write(v[23], v[22], v[21], v[20:17], 1'b0);
            check_query($sformatf("R2-R6 vector %0d", i), v[16:15], v[14:13],
                        v[12], v[11:6], v[5:0]);
        end

        // R7: hidden mask bit reappears after soft reset clears global mode
        mode_write(1'b1, 1'b1, 1'b1, 4'b1000, 1'b0);
        check_query("R4 global 11 on drive0", 2'd0, 2'b00, 1'b1, 6'd41, 6'd38);
        soft_reset();
        check_query("R7 mask kept drive3", 2'd3, 2'b00, 1'b1, 6'd22, 6'd19);
        check_query("R7 mode cleared drive0", 2'd0, 2'b00, 1'b0, 6'd22, 6'd0);

        // R11 configure
        cfg_write(1'b0, 4'd7, 8'd42);
        check_cfg("R11 cfg load", 1'b0, 4'd7, 8'd42);

        // R8 unlocked soft reset restores defaults
        soft_reset();
        check_cfg("R8 unlocked restore", 1'b1, 4'd0, 8'd0);

        // R9 lock reply
        cfg_write(1'b0, 4'd9, 8'd77);
        lock_write(1'b1, 1'b0);
        check("R9 reply valid+byte", {status_valid, status_byte, lock_state}, {1'b1, 8'h10, 1'b1});
        @(negedge clk);
        check("R9 reply one cycle", {status_valid, status_byte}, {1'b0, 8'h00});

        // R8 locked soft reset keeps config, R10 lock unchanged
        soft_reset();
        check_cfg("R8 locked keep", 1'b0, 4'd9, 8'd77);
        check("R10 lock after soft reset", lock_state, 1'b1);

        // R10 collisions
        lock_write(1'b0, 1'b1);
        check("R10 lock cmd dropped", {lock_state, status_valid}, 2'b10);
        mode_write(1'b0, 1'b0, 1'b1, 4'b0000, 1'b1);
        check_query("R10 mode cmd dropped", 2'd3, 2'b11, 1'b1, 6'd41, 6'd38);

        // R9 unlock reply
        lock_write(1'b0, 1'b0);
        check("R9 unlock reply", {status_valid, status_byte, lock_state}, {1'b1, 8'h00, 1'b0});

        // R1 hardware reset clears everything
        cfg_write(1'b0, 4'd3, 8'd5);
        lock_write(1'b1, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_query("R1 hw reset clears mask", 2'd3, 2'b00, 1'b0, 6'd22, 6'd0);
        check_cfg("R1 hw reset cfg", 1'b1, 4'd0, 8'd0);
        check("R1 hw reset lock", {lock_state, status_valid}, 2'b00);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule